// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds a bank of programmable hardware performance counters for a processor core. The core delivers a vector of per-cycle event pulses, grouped into event sets of equal width. Each counter has its own selector register. The low byte of the selector names one event set. The bits above the low byte form a mask over the events in that set. A counter adds one in every cycle where at least one of its masked events is high. Software measures an interval by reading a counter before and after a region of code and subtracting the two values. Configuring a selector never clears its counter.

A simple CSR request port carries an address, a write flag, write data and the privilege level of the requester. The block answers each request exactly one cycle later. The answer is the read data plus an illegal-access flag. Two enable registers decide whether lower privilege levels may read the user-visible counter aliases. The machine-level register gates supervisor reads. The supervisor-level register additionally gates user reads.

The request port has no back-pressure. Every request is accepted in the cycle it is presented. Its response must be consumed in the cycle it appears.

Top module: `pc_bank`

## Requirements
- R1: Selector bits [7:0] hold the event-set number s. Selector bit 8+j selects event j of that set. Event j of set s arrives on `ev_i` bit (s-1)*EVT_PER_SET+j. Only the low 8+EVT_PER_SET selector bits are stored, and the bits above them read as zero.
- R2: A counter adds exactly one in a cycle where any of its selected events is high. This holds however many selected events are high at once. A counter does not change in a cycle where none of its selected events is high.
- R3: A selector whose set number is 0 or larger than NUM_SETS, or whose mask is all zero, never advances its counter.
- R4: A legal CSR write to a counter loads the written value, even if an increment is due in the same cycle. A write to a selector leaves its counter value untouched.
- R5: A counter holding all ones wraps to zero on its next increment.
- R6: A request presented at a rising edge produces `rsp_valid` high for exactly one cycle after that edge. The read data is the register value from before that edge. Without a request, `rsp_valid` is low.
- R7: Counter i has enable bit 3+i in both enable registers. A read of its user alias is always legal from machine privilege (3). From supervisor privilege (1) it needs the machine-level enable bit. From user privilege (0) it needs both enable bits.
- R8: An illegal request sets `rsp_illegal`, returns zero data and changes no register. A write to a user counter alias is always illegal.
- R9: Counters, selectors and the machine-level enable register need machine privilege for both read and write. The supervisor-level enable register needs supervisor or machine privilege.
- R10: After reset, all counters, selectors and both enable registers read zero, and `rsp_valid` is low.
- R11: The address map is as follows. Counter i sits at 0xB03+i for machine access and at 0xC03+i as its user alias. Selector i sits at 0x323+i. The machine-level enable register is at 0x306 and the supervisor-level one at 0x106. Privilege code 2 is treated as user. Any other address answers zero data with `rsp_illegal` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | NUM_SETS*EVT_PER_SET | Per-cycle event pulses, set 1 in the lowest group |
| req_valid | input | 1 | CSR request present this cycle |
| req_we | input | 1 | Request is a write |
| req_addr | input | 12 | CSR address |
| req_wdata | input | 64 | Write data |
| req_priv | input | 2 | Privilege of requester: 0 user, 1 supervisor, 3 machine |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 64 | Read data, zero on an illegal access |
| rsp_illegal | output | 1 | Request was refused |

## Verification
The checker assumes that `req_priv` carries one of the four two-bit codes and that all inputs are known from reset onward. It also assumes that only a CSR write can change counter 0 by more than one step. The randomized stimulus keeps to these assumptions. It draws privileges from all four codes, events as arbitrary bit patterns, and addresses from the mapped registers plus one index past the last counter and one unmapped address. Selector write data is restricted to set numbers 0 to 3 with random masks, so both implemented and unimplemented sets get exercised.

// File: rtl/pc_pkg.sv
package pc_pkg;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_RSV  = 2'd2,
    PRIV_MACH = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_MCTR,
    ACC_MSEL,
    ACC_UCTR,
    ACC_MEN,
    ACC_SEN
  } acc_e;

  localparam logic [11:0] ADDR_MCTR_BASE = 12'hB03;
  localparam logic [11:0] ADDR_MSEL_BASE = 12'h323;
  localparam logic [11:0] ADDR_UCTR_BASE = 12'hC03;
  localparam logic [11:0] ADDR_MEN       = 12'h306;
  localparam logic [11:0] ADDR_SEN       = 12'h106;

  localparam int FIRST_HPM = 3;
  localparam int SET_FIELD_W = 8;

endpackage

// File: rtl/pc_event_match.sv
module pc_event_match
  import pc_pkg::*;
#(
  parameter int NUM_SETS    = 2,
  parameter int EVT_PER_SET = 4,
  localparam int EV_W  = NUM_SETS * EVT_PER_SET,
  localparam int SEL_W = SET_FIELD_W + EVT_PER_SET
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [EV_W-1:0]  ev,
  output logic             fire
);

  logic [SET_FIELD_W-1:0] set_num;
  logic [EVT_PER_SET-1:0] mask;
  logic [NUM_SETS-1:0]    set_hit;

  assign set_num = sel[SET_FIELD_W-1:0];
  assign mask    = sel[SET_FIELD_W +: EVT_PER_SET];

  // one comparator per implemented set; set numbers start at 1
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    assign set_hit[s] = (set_num == SET_FIELD_W'(s + 1)) &&
                        (|(mask & ev[s*EVT_PER_SET +: EVT_PER_SET]));
  end

  assign fire = |set_hit;

endmodule

// File: rtl/pc_counter.sv
module pc_counter
  import pc_pkg::*;
#(
  parameter int CTR_W       = 64,
  parameter int NUM_SETS    = 2,
  parameter int EVT_PER_SET = 4,
  localparam int EV_W  = NUM_SETS * EVT_PER_SET,
  localparam int SEL_W = SET_FIELD_W + EVT_PER_SET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_W-1:0]  ev,
  input  logic             sel_we,
  input  logic             ctr_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [CTR_W-1:0] ctr_wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic [CTR_W-1:0] ctr_q
);

  logic fire;

  pc_event_match #(
    .NUM_SETS   (NUM_SETS),
    .EVT_PER_SET(EVT_PER_SET)
  ) u_match (
    .sel (sel_q),
    .ev  (ev),
    .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= sel_wdata;
    end
  end

  // software write wins over an increment in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr_q <= '0;
    end else if (ctr_we) begin
      ctr_q <= ctr_wdata;
    end else if (fire) begin
      ctr_q <= ctr_q + CTR_W'(1);
    end
  end

endmodule

// File: rtl/pc_access.sv
module pc_access
  import pc_pkg::*;
#(
  parameter int NUM_CTR = 4,
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic [11:0]      addr,
  input  logic             we,
  input  logic [1:0]       priv,
  input  logic [31:0]      men,
  input  logic [31:0]      sen,
  output acc_e             kind,
  output logic [IDX_W-1:0] idx,
  output logic             illegal
);

  logic [11:0] off_mc, off_ms, off_uc;
  logic        hit_mc, hit_ms, hit_uc;
  logic        is_mach, is_sup;
  logic [4:0]  gate_pos;

  assign off_mc = addr - ADDR_MCTR_BASE;
  assign off_ms = addr - ADDR_MSEL_BASE;
  assign off_uc = addr - ADDR_UCTR_BASE;
  assign hit_mc = off_mc < 12'(NUM_CTR);
  assign hit_ms = off_ms < 12'(NUM_CTR);
  assign hit_uc = off_uc < 12'(NUM_CTR);

  assign is_mach = (priv == PRIV_MACH);
  assign is_sup  = (priv == PRIV_SUP);

  always_comb begin
    kind = ACC_NONE;
    idx  = '0;
    if (hit_mc) begin
      kind = ACC_MCTR;
      idx  = off_mc[IDX_W-1:0];
    end else if (hit_ms) begin
      kind = ACC_MSEL;
      idx  = off_ms[IDX_W-1:0];
    end else if (hit_uc) begin
      kind = ACC_UCTR;
      idx  = off_uc[IDX_W-1:0];
    end else if (addr == ADDR_MEN) begin
      kind = ACC_MEN;
    end else if (addr == ADDR_SEN) begin
      kind = ACC_SEN;
    end
  end

  assign gate_pos = 5'(FIRST_HPM) + 5'(idx);

  always_comb begin
    unique case (kind)
      ACC_MCTR, ACC_MSEL, ACC_MEN: illegal = !is_mach;
      ACC_SEN:                     illegal = !(is_mach || is_sup);
      ACC_UCTR: begin
        if (we)           illegal = 1'b1;
        else if (is_mach) illegal = 1'b0;
        else if (is_sup)  illegal = !men[gate_pos];
        else              illegal = !(men[gate_pos] && sen[gate_pos]);
      end
      default:                     illegal = 1'b0;
    endcase
  end

endmodule

// File: rtl/pc_bank.sv
module pc_bank
  import pc_pkg::*;
#(
  parameter int NUM_CTR     = 4,
  parameter int CTR_W       = 64,
  parameter int NUM_SETS    = 2,
  parameter int EVT_PER_SET = 4,
  localparam int EV_W  = NUM_SETS * EVT_PER_SET,
  localparam int SEL_W = SET_FIELD_W + EVT_PER_SET,
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_i,
  input  logic            req_valid,
  input  logic            req_we,
  input  logic [11:0]     req_addr,
  input  logic [63:0]     req_wdata,
  input  logic [1:0]      req_priv,
  output logic            rsp_valid,
  output logic [63:0]     rsp_rdata,
  output logic            rsp_illegal
);

  acc_e             acc_kind;
  logic [IDX_W-1:0] acc_idx;
  logic             acc_illegal;
  logic             wr_ok;
  logic [31:0]      men_q, sen_q;
  logic [63:0]      rd_val;

  logic [CTR_W-1:0] ctr_q  [NUM_CTR];
  logic [SEL_W-1:0] sel_q  [NUM_CTR];
  logic [NUM_CTR-1:0] ctr_we, sel_we;

  pc_access #(
    .NUM_CTR(NUM_CTR)
  ) u_access (
    .addr   (req_addr),
    .we     (req_we),
    .priv   (req_priv),
    .men    (men_q),
    .sen    (sen_q),
    .kind   (acc_kind),
    .idx    (acc_idx),
    .illegal(acc_illegal)
  );

  assign wr_ok = req_valid && req_we && !acc_illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      men_q <= '0;
      sen_q <= '0;
    end else if (wr_ok) begin
      if (acc_kind == ACC_MEN) men_q <= req_wdata[31:0];
      if (acc_kind == ACC_SEN) sen_q <= req_wdata[31:0];
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign ctr_we[i] = wr_ok && (acc_kind == ACC_MCTR) && (acc_idx == IDX_W'(i));
    assign sel_we[i] = wr_ok && (acc_kind == ACC_MSEL) && (acc_idx == IDX_W'(i));

    pc_counter #(
      .CTR_W      (CTR_W),
      .NUM_SETS   (NUM_SETS),
      .EVT_PER_SET(EVT_PER_SET)
    ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev_i),
      .sel_we   (sel_we[i]),
      .ctr_we   (ctr_we[i]),
      .sel_wdata(req_wdata[SEL_W-1:0]),
      .ctr_wdata(req_wdata[CTR_W-1:0]),
      .sel_q    (sel_q[i]),
      .ctr_q    (ctr_q[i])
    );
  end

  always_comb begin
    rd_val = '0;
    if (!acc_illegal) begin
      unique case (acc_kind)
        ACC_MCTR, ACC_UCTR: rd_val = 64'(ctr_q[acc_idx]);
        ACC_MSEL:           rd_val = 64'(sel_q[acc_idx]);
        ACC_MEN:            rd_val = {32'd0, men_q};
        ACC_SEN:            rd_val = {32'd0, sen_q};
        default:            rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_rdata   <= req_valid ? rd_val : '0;
      rsp_illegal <= req_valid && acc_illegal;
    end
  end

endmodule

// File: rtl/pc_bank_chk.sv
module pc_bank_chk #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_we,
  input logic [11:0]      req_addr,
  input logic [1:0]       req_priv,
  input logic             rsp_valid,
  input logic [63:0]      rsp_rdata,
  input logic             rsp_illegal,
  input logic             ev_idle,
  input logic [CTR_W-1:0] ctr0,
  input logic             ctr0_we
);

  logic [11:0] off_u, off_m;
  logic        in_ualias, in_mctr;

  assign off_u     = req_addr - 12'hC03;
  assign off_m     = req_addr - 12'hB03;
  assign in_ualias = off_u < 12'(NUM_CTR);
  assign in_mctr   = off_m < 12'(NUM_CTR);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R6

  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R6

  AST_ILLEGAL_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (rsp_valid && rsp_rdata == 64'd0)); // R8

  AST_UALIAS_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && in_ualias) |=> rsp_illegal); // R8

  AST_MACHINE_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_priv == 2'd3 && in_ualias) |=> !rsp_illegal); // R7

  AST_LOWPRIV_MCTR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv != 2'd3 && in_mctr) |=> rsp_illegal); // R9

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr0_we |=> (ctr0 == $past(ctr0) || ctr0 == $past(ctr0) + CTR_W'(1))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctr0_we && ev_idle) |=> $stable(ctr0)); // R2

endmodule

bind pc_bank pc_bank_chk #(
  .NUM_CTR(NUM_CTR),
  .CTR_W  (CTR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_we     (req_we),
  .req_addr   (req_addr),
  .req_priv   (req_priv),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_illegal(rsp_illegal),
  .ev_idle    (ev_i == '0),
  .ctr0       (ctr_q[0]),
  .ctr0_we    (ctr_we[0])
);

// File: tb/pc_bank_bench.sv
module pc_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC  = 4;
  localparam int NS  = 2;
  localparam int EPS = 4;
  localparam int EVW = NS * EPS;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [EVW-1:0]  ev_i;
  logic            req_valid, req_we;
  logic [11:0]     req_addr;
  logic [63:0]     req_wdata;
  logic [1:0]      req_priv;
  logic            rsp_valid, rsp_illegal;
  logic [63:0]     rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] m_ctr [NC];
  logic [11:0] m_sel [NC];
  logic [31:0] m_men, m_sen;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_bank #(
    .NUM_CTR(NC), .CTR_W(64), .NUM_SETS(NS), .EVT_PER_SET(EPS)
  ) u_pc_bank (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
  );

  function automatic bit m_fire(input logic [11:0] sel, input logic [EVW-1:0] ev);
    int s;
    s = int'(sel[7:0]);
    if (s < 1 || s > NS) return 1'b0;
    return |(sel[11:8] & ev[(s-1)*EPS +: EPS]);
  endfunction

  // kinds: 0 none, 1 machine counter, 2 selector, 3 user alias, 4 men, 5 sen
  function automatic void m_decode(input logic [11:0] a, input bit we, input logic [1:0] p,
                                   output int kind, output int idx, output bit ill);
    logic [11:0] o;
    bit m_ok, s_ok;
    kind = 0; idx = 0;
    m_ok = (p == 2'd3);
    s_ok = (p == 2'd1);
    o = a - 12'hB03;
    if (o < 12'(NC)) begin kind = 1; idx = int'(o); end
    o = a - 12'h323;
    if (kind == 0 && o < 12'(NC)) begin kind = 2; idx = int'(o); end
    o = a - 12'hC03;
    if (kind == 0 && o < 12'(NC)) begin kind = 3; idx = int'(o); end
    if (kind == 0 && a == 12'h306) kind = 4;
    if (kind == 0 && a == 12'h106) kind = 5;
    case (kind)
      1, 2, 4: ill = !m_ok;
      5:       ill = !(m_ok || s_ok);
      3: begin
        if (we)        ill = 1'b1;
        else if (m_ok) ill = 1'b0;
        else if (s_ok) ill = !m_men[3+idx];
        else           ill = !(m_men[3+idx] && m_sen[3+idx]);
      end
      default: ill = 1'b0;
    endcase
  endfunction

  task automatic cyc(input bit v, input bit we, input logic [11:0] a, input logic [63:0] wd,
                     input logic [1:0] p, input logic [EVW-1:0] ev, input string tag);
    int kind, idx;
    bit ill, wr;
    logic [63:0] ed;
    bit fires [NC];
    req_valid = v; req_we = we; req_addr = a; req_wdata = wd; req_priv = p; ev_i = ev;
    m_decode(a, we, p, kind, idx, ill);
    ed = 64'd0;
    if (!ill) begin
      case (kind)
        1, 3: ed = m_ctr[idx];
        2:    ed = 64'(m_sel[idx]);
        4:    ed = 64'(m_men);
        5:    ed = 64'(m_sen);
        default: ed = 64'd0;
      endcase
    end
    wr = v && we && !ill;
    for (int i = 0; i < NC; i++) fires[i] = m_fire(m_sel[i], ev);
    for (int i = 0; i < NC; i++) begin
      if (wr && kind == 1 && idx == i) m_ctr[i] = wd;
      else if (fires[i]) m_ctr[i] = m_ctr[i] + 64'd1;
    end
    if (wr && kind == 2) m_sel[idx] = wd[11:0];
    if (wr && kind == 4) m_men = wd[31:0];
    if (wr && kind == 5) m_sen = wd[31:0];
    @(posedge clk);
    #1;
    checks++;
    if (v) begin
      if (!(rsp_valid === 1'b1 && rsp_illegal === ill && rsp_rdata === (ill ? 64'd0 : ed))) begin
        failures++;
        $display("FAIL %s addr=%h priv=%0d we=%0b: actual v=%0b ill=%0b data=%h expected v=1 ill=%0b data=%h",
                 tag, a, p, we, rsp_valid, rsp_illegal, rsp_rdata, ill, ed);
      end
    end else if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL %s idle cycle: actual rsp_valid=%0b expected 0", tag, rsp_valid);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] p, input string tag);
    cyc(1'b1, 1'b0, a, 64'd0, p, '0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [1:0] p, input string tag);
    cyc(1'b1, 1'b1, a, d, p, '0, tag);
  endtask

  task automatic idle(input logic [EVW-1:0] ev, input string tag);
    cyc(1'b0, 1'b0, 12'h000, 64'd0, 2'd3, ev, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual run still active, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NC; i++) begin m_ctr[i] = '0; m_sel[i] = '0; end
    m_men = '0; m_sen = '0;
    rst_n = 1'b0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0; req_priv = '0; ev_i = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R10 reset: actual rsp_valid=%0b expected 0", rsp_valid);
    end
    rst_n = 1'b1;

    // R10: everything reads zero after reset
    for (int i = 0; i < NC; i++) begin
      rd(12'hB03 + 12'(i), 2'd3, "R10 counter");
      rd(12'h323 + 12'(i), 2'd3, "R10 selector");
    end
    rd(12'h306, 2'd3, "R10 men");
    rd(12'h106, 2'd3, "R10 sen");
    idle('0, "R6 idle");

    // R1: selector format and storage width
    wr(12'h323, 64'hFFFF_FFFF_FFFF_F101, 2'd3, "R1 sel0 write");
    rd(12'h323, 2'd3, "R1 sel0 readback");
    wr(12'h323, 64'h101, 2'd3, "R1 sel0");
    wr(12'h324, 64'h801, 2'd3, "R1 sel1");
    wr(12'h325, 64'h302, 2'd3, "R1 sel2");
    wr(12'h326, 64'hF00, 2'd3, "R3 sel3 set zero");
    // R2: single and multiple events
    idle(8'b0000_0001, "R2 set1 ev0");
    idle(8'b0000_1000, "R2 set1 ev3");
    idle(8'b0011_1001, "R2 many at once");
    idle(8'b0001_0000, "R2 set2 ev0");
    idle(8'b1100_0110, "R2 unselected only");
    for (int i = 0; i < NC; i++) rd(12'hB03 + 12'(i), 2'd3, "R2 counter value");

    // R3: unimplemented set and empty mask
    wr(12'h326, 64'hF03, 2'd3, "R3 sel3 set three");
    idle('1, "R3 all events");
    wr(12'h326, 64'h001, 2'd3, "R3 sel3 empty mask");
    idle('1, "R3 all events");
    rd(12'hB06, 2'd3, "R3 counter3 zero");

    // R4: write beats increment; selector write keeps count
    cyc(1'b1, 1'b1, 12'hB03, 64'h1234, 2'd3, 8'h01, "R4 write vs increment");
    rd(12'hB03, 2'd3, "R4 written value");
    wr(12'h323, 64'h202, 2'd3, "R4 reselect");
    rd(12'hB03, 2'd3, "R4 count kept");

    // R5: wrap
    wr(12'hB04, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, "R5 preload");
    idle(8'h08, "R5 increment");
    rd(12'hB04, 2'd3, "R5 wrapped");

    // R7: gating by enables
    wr(12'h306, 64'h8, 2'd3, "R9 men write");
    rd(12'hC03, 2'd0, "R7 user blocked by sen");
    rd(12'hC03, 2'd1, "R7 sup allowed");
    rd(12'hC04, 2'd1, "R7 sup blocked");
    rd(12'hC04, 2'd3, "R7 machine always");
    wr(12'h106, 64'h8, 2'd1, "R9 sen write by sup");
    rd(12'hC03, 2'd0, "R7 user allowed");
    rd(12'hC03, 2'd2, "R11 priv2 as user");
    rd(12'hC04, 2'd2, "R11 priv2 blocked");

    // R8 / R9: refused accesses change nothing
    wr(12'hC03, 64'h55, 2'd3, "R8 alias write");
    rd(12'hB03, 2'd3, "R8 counter untouched");
    wr(12'hB03, 64'h77, 2'd1, "R9 sup counter write");
    wr(12'h323, 64'h101, 2'd0, "R9 user selector write");
    wr(12'h106, 64'hFFFF, 2'd0, "R9 user sen write");
    rd(12'h306, 2'd1, "R9 sup men read");
    rd(12'hB03, 2'd3, "R8 counter still");
    rd(12'h323, 2'd3, "R8 selector still");
    rd(12'h106, 2'd3, "R8 sen still");
    rd(12'h800, 2'd0, "R11 unmapped");
    rd(12'hB03 + 12'(NC), 2'd0, "R11 past last");

    // randomized mix
    for (int n = 0; n < 4000; n++) begin
      int k, ix;
      logic [11:0] a;
      logic [63:0] d;
      k  = int'($urandom_range(0, 5));
      ix = int'($urandom_range(0, NC));
      case (k)
        0: a = 12'hB03 + 12'(ix);
        1: a = 12'h323 + 12'(ix);
        2: a = 12'hC03 + 12'(ix);
        3: a = 12'h306;
        4: a = 12'h106;
        default: a = 12'h800;
      endcase
      d = {$urandom, $urandom};
      if (k == 1) d = {52'd0, 4'($urandom), 8'($urandom_range(0, 3))};
      else if (k == 0 && $urandom_range(0, 3) == 0) d = 64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom_range(0, 15));
      cyc(1'($urandom), 1'($urandom), a, d, 2'($urandom), EVW'($urandom), "R6 random mix");
    end
    for (int i = 0; i < NC; i++) rd(12'hB03 + 12'(i), 2'd3, "R2 final counters");

    finish_run();
  end

endmodule